// File: doc/BRIEF.md
# Transmitter Event Interrupt and Soft-Reset Register Unit

This block gathers single-cycle event pulses from a display transmitter into a latched status register. Software reads and clears that register over a simple 32-bit register port. Each status bit has its own enable bit. One level-sensitive interrupt line asserts when an enabled status bit is pending and the global enable is set.

The block also holds the soft-reset request bit of the configuration register and drives it out as `srst_out`. Soft-reset completion is recognised only while an auxiliary clock is reported as running. The completion is reported in two places: as a level in the general status register, and as a latched event on the same interrupt path as the other sources.

Reads return data on the cycle after `rd_en`. Writes take effect at the clock edge on which `wr_en` is sampled.

Top module: `txev_irq_unit`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `srst_out` is 0.
- R2: A pulse on `ev_pulse[i]` sets its status bit at the next edge, whatever the enable register holds. The status bits are: [0] pixel capture to bit 3, [1] hot plug to bit 4, [2] PLL lock to bit 5, [3] new frame to bit 6, [4] packet sent to bit 7, [5] sink termination to bit 11.
- R3: Writing to the clear register (offset 0x00C) clears each status bit whose `wdata` bit is 1 and leaves the others. Writing 0xFFFFFFFF clears everything pending.
- R4: When an event pulse and a clear of the same bit land in the same cycle, the bit ends up set.
- R5: `irq` is 1 exactly when enable bit 0 is 1 and some status bit among bits 1 to 11 is 1 with its enable bit also 1.
- R6: The enable register (offset 0x004) is read/write. Only bits 0, 1, 3, 4, 5, 6, 7 and 11 are stored; every other bit reads 0.
- R7: Configuration register (offset 0x000) bit 31 is the soft-reset request. It drives `srst_out` from the edge after the write and holds until software writes it to 0. The other bits of this register read 0.
- R8: General status register (offset 0x010) bit 1 reads 1 only when, on the previous cycle, the request was set and `aux_on` was 1. All other bits read 0.
- R9: Status bit 1 (soft-reset done) is set once, on the rising of the condition (request AND `aux_on`). It is never set while `aux_on` is 0.
- R10: Reading the status register has no side effect. Writes to the status (0x008) and general status (0x010) offsets are ignored.
- R11: `rdata` shows the addressed register on the cycle after `rd_en` and 0 otherwise. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| ev_pulse | input | SRC_N | One-cycle event pulses from the transmitter sources |
| aux_on | input | 1 | Synchronous level: auxiliary clock running |
| irq | output | 1 | Level interrupt |
| srst_out | output | 1 | Soft-reset request to the transmitter |

## Verification
The bench targets four corner cases:
- A clear that lands in the same cycle as a new event. A design that ordered these wrongly would lose the event.
- A soft-reset request raised while the auxiliary clock is stopped. A faulty design would flag completion early, or would flag it again after software cleared it.
- The gating of the interrupt by the global enable. A design that ignored that bit would assert the line while interrupts are meant to be off.
- Writes to read-only offsets and to unimplemented enable bits. A careless decoder would let these corrupt the pending state, which shows up at the next status read.

// File: rtl/txev_pkg.sv
package txev_pkg;
    localparam int DW     = 32;
    localparam int STS_W  = 12;
    localparam int SRC_N  = 6;
    localparam int B_GLB  = 0;
    localparam int B_SRST = 1;
    localparam int B_REQ  = 31;

    // word indices of the register map
    localparam int WI_CFG  = 0;
    localparam int WI_EN   = 1;
    localparam int WI_STS  = 2;
    localparam int WI_CLR  = 3;
    localparam int WI_GSTA = 4;

    typedef enum logic [2:0] {
        SEL_CFG, SEL_EN, SEL_STS, SEL_CLR, SEL_GSTA, SEL_NONE
    } reg_sel_t;

    typedef struct packed {
        logic [STS_W-1:0] en;
        logic [STS_W-1:0] sts;
    } irq_state_t;

    typedef struct packed {
        logic req;
        logic cond;
    } srst_state_t;

    // status bit that source i lands on
    function automatic int src_pos(input int i);
        case (i)
            0: return 3;
            1: return 4;
            2: return 5;
            3: return 6;
            4: return 7;
            default: return 11;
        endcase
    endfunction

    function automatic logic [STS_W-1:0] impl_mask();
        logic [STS_W-1:0] m;
        m = '0;
        m[B_GLB]  = 1'b1;
        m[B_SRST] = 1'b1;
        for (int i = 0; i < SRC_N; i++) m[src_pos(i)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/txev_decode.sv
module txev_decode
    import txev_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel,
    output logic              cfg_wr,
    output logic              en_wr,
    output logic              clr_wr
);
    localparam int WW = ADDR_W - 2;

    logic [WW-1:0] word;
    logic [1:0]    unused_lsb;

    assign word       = addr[ADDR_W-1:2];
    assign unused_lsb = addr[1:0];

    always_comb begin
        if      (word == WW'(WI_CFG))  sel = SEL_CFG;
        else if (word == WW'(WI_EN))   sel = SEL_EN;
        else if (word == WW'(WI_STS))  sel = SEL_STS;
        else if (word == WW'(WI_CLR))  sel = SEL_CLR;
        else if (word == WW'(WI_GSTA)) sel = SEL_GSTA;
        else                           sel = SEL_NONE;
    end

    assign cfg_wr = wr_en && (sel == SEL_CFG);
    assign en_wr  = wr_en && (sel == SEL_EN);
    assign clr_wr = wr_en && (sel == SEL_CLR);
endmodule

// File: rtl/txev_irqcore.sv
module txev_irqcore
    import txev_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             clr_wr,
    input  logic [STS_W-1:0] wbits,
    input  logic [STS_W-1:0] set_vec,
    output logic [STS_W-1:0] en_q,
    output logic [STS_W-1:0] sts_q,
    output logic             irq
);
    localparam logic [STS_W-1:0] MASK = impl_mask();

    irq_state_t st_d, st_q;
    logic [STS_W-1:0] clr_bits;

    always_comb begin
        st_d     = st_q;
        clr_bits = clr_wr ? wbits : '0;
        if (en_wr) st_d.en = wbits & MASK;
        // set is applied after clear so a same-cycle event survives
        st_d.sts = ((st_q.sts & ~clr_bits) | set_vec) & MASK & ~STS_W'(1 << B_GLB);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q  = st_q.en;
    assign sts_q = st_q.sts;
    assign irq   = st_q.en[B_GLB] & (|(st_q.sts[STS_W-1:1] & st_q.en[STS_W-1:1]));
endmodule

// File: rtl/txev_srst.sv
module txev_srst
    import txev_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic req_bit,
    input  logic aux_on,
    output logic req_q,
    output logic done_pulse,
    output logic gsta_q
);
    srst_state_t s_d, s_q;
    logic live;

    always_comb begin
        s_d        = s_q;
        live       = s_q.req & aux_on;
        if (cfg_wr) s_d.req = req_bit;
        s_d.cond   = live;
        done_pulse = live & ~s_q.cond;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_q  = s_q.req;
    assign gsta_q = s_q.cond;
endmodule

// File: rtl/txev_rdmux.sv
module txev_rdmux
    import txev_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  reg_sel_t         sel,
    input  logic             req_q,
    input  logic [STS_W-1:0] en_q,
    input  logic [STS_W-1:0] sts_q,
    input  logic             gsta_q,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] rd_d, rd_q, val;

    always_comb begin
        val = '0;
        case (sel)
            SEL_CFG:  val[B_REQ] = req_q;
            SEL_EN:   val[STS_W-1:0] = en_q;
            SEL_STS:  val[STS_W-1:0] = sts_q;
            SEL_GSTA: val[B_SRST] = gsta_q;
            default:  val = '0;
        endcase
        rd_d = rd_en ? val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q;
endmodule

// File: rtl/txev_irq_unit.sv
module txev_irq_unit
    import txev_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [SRC_N-1:0]  ev_pulse,
    input  logic              aux_on,
    output logic              irq,
    output logic              srst_out
);
    reg_sel_t         sel;
    logic             cfg_wr, en_wr, clr_wr;
    logic             done_pulse, gsta_q, req_q;
    logic [STS_W-1:0] en_q, sts_q, set_vec;
    logic [STS_W-1:0] src_hot [SRC_N];
    logic             unused_wbits;

    assign unused_wbits = ^wdata[DW-2:STS_W];

    txev_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en(wr_en), .addr(addr), .sel(sel),
        .cfg_wr(cfg_wr), .en_wr(en_wr), .clr_wr(clr_wr)
    );

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        assign src_hot[g] = ev_pulse[g] ? (STS_W'(1) << src_pos(g)) : '0;
    end

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < SRC_N; i++) set_vec = set_vec | src_hot[i];
        set_vec[B_SRST] = set_vec[B_SRST] | done_pulse;
    end

    txev_srst u_srst (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .req_bit(wdata[B_REQ]),
        .aux_on(aux_on), .req_q(req_q), .done_pulse(done_pulse), .gsta_q(gsta_q)
    );

    txev_irqcore u_core (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .clr_wr(clr_wr),
        .wbits(wdata[STS_W-1:0]), .set_vec(set_vec),
        .en_q(en_q), .sts_q(sts_q), .irq(irq)
    );

    txev_rdmux u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel(sel), .req_q(req_q),
        .en_q(en_q), .sts_q(sts_q), .gsta_q(gsta_q), .rdata(rdata)
    );

    assign srst_out = req_q;
endmodule

// File: rtl/txev_irq_chk.sv
module txev_irq_chk
    import txev_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic [SRC_N-1:0]  ev_pulse,
    input logic              aux_on,
    input logic              irq,
    input logic              srst_out,
    input logic [STS_W-1:0]  en_q,
    input logic [STS_W-1:0]  sts_q,
    input logic              gsta_q
);
    // R7
    req_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[ADDR_W-1:2] == '0) |=> (srst_out == $past(wdata[B_REQ])));

    // R7
    req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr[ADDR_W-1:2] == '0) |=> $stable(srst_out));

    // R2
    pll_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse[2] |=> sts_q[5]);

    // R4
    hot_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse[1] |=> sts_q[4]);

    // R5
    global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[B_GLB] |-> !irq);

    // R9
    done_needs_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[B_SRST]) |-> ($past(aux_on) && $past(srst_out)));

    // R8
    gsta_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gsta_q |-> $past(srst_out));
endmodule

bind txev_irq_unit txev_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ev_pulse(ev_pulse), .aux_on(aux_on), .irq(irq), .srst_out(srst_out),
    .en_q(en_q), .sts_q(sts_q), .gsta_q(gsta_q)
);

// File: tb/sim_txev_irq_unit.sv
`timescale 1ns/1ps
module sim_txev_irq_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, rd_en = 0, aux_on = 0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [5:0]  ev_pulse = '0;
    logic [31:0] rdata;
    logic        irq, srst_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // behavioural reference state
    bit [31:0] m_en, m_sts, m_rd;
    bit        m_req, m_cond;

    txev_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ev_pulse(ev_pulse), .aux_on(aux_on),
        .irq(irq), .srst_out(srst_out)
    );

    always #4 clk = ~clk;

    function automatic bit [31:0] m_read(input int a);
        case (a >> 2)
            0: return {m_req, 31'b0};
            1: return m_en;
            2: return m_sts;
            4: return {30'b0, m_cond, 1'b0};
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit [31:0] n_en, n_sts, n_rd, setb;
        bit        n_req, n_cond, live;
        int        w;
        if (!rst_n) begin
            m_en = 0; m_sts = 0; m_rd = 0; m_req = 0; m_cond = 0;
        end else begin
            w = int'(addr) >> 2;
            n_rd = rd_en ? m_read(int'(addr)) : 0;
            n_en = (wr_en && w == 1) ? (wdata & 32'h8FB) : m_en;
            n_req = (wr_en && w == 0) ? wdata[31] : m_req;
            live = m_req && aux_on;
            n_cond = live;
            setb = 0;
            if (ev_pulse[0]) setb[3] = 1;
            if (ev_pulse[1]) setb[4] = 1;
            if (ev_pulse[2]) setb[5] = 1;
            if (ev_pulse[3]) setb[6] = 1;
            if (ev_pulse[4]) setb[7] = 1;
            if (ev_pulse[5]) setb[11] = 1;
            if (live && !m_cond) setb[1] = 1;
            n_sts = m_sts;
            if (wr_en && w == 3) n_sts = n_sts & ~wdata;
            n_sts = n_sts | setb;
            m_en = n_en; m_sts = n_sts; m_rd = n_rd; m_req = n_req; m_cond = n_cond;
        end
    end

    task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5 irq vs model", {31'b0, irq},
                  {31'b0, m_en[0] && ((m_sts & m_en & 32'hFFE) != 0)});
            check("R7 srst_out vs model", {31'b0, srst_out}, {31'b0, m_req});
            check("R11 rdata vs model", rdata, m_rd);
        end
    end

    task automatic wr(input bit [11:0] a, input bit [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0; wdata = 0;
    endtask

    task automatic rd(input bit [11:0] a, input string tag, input bit [31:0] exp);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0;
        check(tag, rdata, exp);
    endtask

    task automatic pulse(input bit [5:0] p, input bit clr, input bit [31:0] cd);
        @(negedge clk); ev_pulse = p;
        if (clr) begin wr_en = 1; addr = 12'h00C; wdata = cd; end
        @(negedge clk); ev_pulse = 0; wr_en = 0; wdata = 0;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 srst_out", {31'b0, srst_out}, 0);
        rd(12'h000, "R1 cfg", 0);
        rd(12'h004, "R1 enable", 0);
        rd(12'h008, "R1 status", 0);
        rd(12'h010, "R1 gsta", 0);
        // R6 implemented enable bits
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h004, "R6 enable mask", 32'h0000_08FB);
        wr(12'h004, 0);
        // R2 event sets status with enable off
        pulse(6'b000010, 0, 0);
        rd(12'h008, "R2 hot plug bit4", 32'h10);
        check("R5 no irq without enable", {31'b0, irq}, 0);
        wr(12'h004, 32'h10);
        @(negedge clk);
        check("R5 no irq without global", {31'b0, irq}, 0);
        wr(12'h004, 32'h11);
        @(negedge clk);
        check("R5 irq with global", {31'b0, irq}, 1);
        // R10 read has no side effect, read-only writes ignored
        rd(12'h008, "R10 status read again", 32'h10);
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h008, "R10 status after ro write", 32'h10);
        // R3 clear
        wr(12'h00C, 32'h8);
        rd(12'h008, "R3 clear other bit", 32'h10);
        wr(12'h00C, 32'h10);
        rd(12'h008, "R3 clear own bit", 0);
        check("R5 irq drops", {31'b0, irq}, 0);
        // R2 all sources at once
        pulse(6'b111111, 0, 0);
        rd(12'h008, "R2 all sources", 32'h8F8);
        wr(12'h00C, 32'hFFFF_FFFF);
        rd(12'h008, "R3 clear all", 0);
        // R4 set beats clear
        pulse(6'b000100, 1, 32'h20);
        rd(12'h008, "R4 pll survives clear", 32'h20);
        wr(12'h00C, 32'hFFFF_FFFF);
        // R7, R8, R9 soft reset without aux clock
        wr(12'h000, 32'h8000_0000);
        check("R7 srst_out set", {31'b0, srst_out}, 1);
        rd(12'h000, "R7 cfg readback", 32'h8000_0000);
        repeat (3) @(negedge clk);
        rd(12'h010, "R8 gsta aux off", 0);
        rd(12'h008, "R9 no done with aux off", 0);
        // aux starts
        @(negedge clk); aux_on = 1;
        repeat (2) @(negedge clk);
        rd(12'h010, "R8 gsta aux on", 32'h2);
        rd(12'h008, "R9 done set", 32'h2);
        wr(12'h004, 32'h3);
        @(negedge clk);
        check("R5 done irq", {31'b0, irq}, 1);
        wr(12'h00C, 32'h2);
        repeat (3) @(negedge clk);
        rd(12'h008, "R9 no refire", 0);
        check("R7 request held", {31'b0, srst_out}, 1);
        wr(12'h000, 0);
        check("R7 srst_out cleared", {31'b0, srst_out}, 0);
        @(negedge clk);
        rd(12'h010, "R8 gsta after release", 0);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, "R7 cfg other bits", 32'h8000_0000);
        rd(12'h100, "R11 unmapped", 0);
        wr(12'h000, 0);
        aux_on = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule